// File: doc/BRIEF.md
# Master-Clock Ratio and Serial-Mode Detector

This block runs on the master clock of an audio converter. It watches two asynchronous inputs. The first is the frame clock, which marks left/right sample frames. The second is a shared control pin. That pin carries either a steady level that requests de-emphasis, or a free-running external bit clock. Both inputs pass through two-flop synchronizers before any edge is taken from them.

The block counts master-clock cycles between rising edges of the frame clock. It sorts the count into one of five legal ratios and derives the rate mode from that ratio. It accepts a ratio only when two frames in a row agree. It treats the shared pin as an external bit clock once enough rising edges fall inside one frame. It drops back to internal bit-clock mode after frames with no edges at all. When the pin holds a level, the block filters it over several falling edges of the frame clock and produces a de-emphasis enable. That enable is gated off whenever the bit clock is external or the rate mode is high.

The outputs are plain control levels for the data-capture and filter logic that follows. No data moves through this block, so no stream handshake is involved.

Top module: `clkmode_detect`

## Requirements
- R1: The master-clock count between two rising frame-clock edges sets `ratio_code_o` as follows: 128→0, 192→1, 256→2, 384→3 and 512→4. Any count within ±2 cycles of a legal ratio is classified as that ratio.
- R2: When a frame's count is more than 2 cycles from every legal ratio, `ratio_valid_o` goes low, and `ratio_code_o` and `high_rate_o` keep their last accepted values.
- R3: A ratio is accepted, setting `ratio_valid_o` high and updating `ratio_code_o`, only when two consecutive frames give the same classification. A frame whose classification differs from the one before it drives `ratio_valid_o` low.
- R4: `high_rate_o` is 1 for accepted codes 0 and 1, and 0 for accepted codes 2, 3 and 4.
- R5: `ext_bclk_o` goes high once 16 rising edges of the shared pin occur between two rising frame-clock edges. A frame with only 15 edges leaves it low.
- R6: `ext_bclk_o` goes low after 2 consecutive frames with no rising edge on the shared pin. A single quiet frame leaves it high.
- R7: The filtered de-emphasis state turns on when the shared pin is low at 5 consecutive frame-clock falling edges. It turns off when the pin is high at 5 consecutive falling edges. A run of 4 changes nothing.
- R8: `deemph_o` is 0 whenever `ext_bclk_o` or `high_rate_o` is 1. Otherwise it follows the filtered state.
- R9: While `rst_n` is low, the outputs hold these values: `ratio_valid_o`=0, `ratio_code_o`=7, `high_rate_o`=0, `ext_bclk_o`=0 and `deemph_o`=0.
- R10: `ratio_valid_o` rises and `ext_bclk_o` falls only in the cycle after a synchronized rising frame-clock edge. The de-emphasis state changes only in the cycle after a synchronized falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk_i | input | 1 | Left/right frame clock, asynchronous |
| mode_pin_i | input | 1 | Shared pin: de-emphasis level or external bit clock |
| ratio_code_o | output | 3 | Accepted ratio code (0..4), 7 before any acceptance |
| ratio_valid_o | output | 1 | Ratio accepted and currently stable |
| high_rate_o | output | 1 | High-rate mode (ratio 128 or 192) |
| ext_bclk_o | output | 1 | External bit clock detected |
| deemph_o | output | 1 | De-emphasis enable |

## Verification
The bench builds the block with its default parameters. These are a ratio unit of 64 (legal counts 128 to 512), a tolerance of 2, an edge threshold of 16, 2 quiet frames and a filter run of 5. With these values every legal ratio and both tolerance limits (254/258 passing, 253 failing) fit inside short frame sequences. Directed frames with exactly 15 and 16 pin pulses, one and two quiet frames, and runs of 4 and 5 de-emphasis samples test each threshold from both sides.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [2:0] {
    RATIO_128  = 3'd0,
    RATIO_192  = 3'd1,
    RATIO_256  = 3'd2,
    RATIO_384  = 3'd3,
    RATIO_512  = 3'd4,
    RATIO_NONE = 3'd7
  } ratio_e;

  localparam int NUM_RATIOS = 5;

  // multiplier of the ratio unit for each code: 2,3,4,6,8
  function automatic int ratio_mult(input int idx);
    return (2 + (idx & 1)) << (idx >> 1);
  endfunction
endpackage

// File: rtl/clkmode_sync.sv
module clkmode_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic level_d_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_i};
  end

  assign level_o   = sh[STAGES-1];
  assign level_d_o = sh[STAGES];
endmodule

// File: rtl/clkmode_ratio.sv
module clkmode_ratio
  import clkmode_pkg::*;
#(
  parameter int UNIT = 64,
  parameter int TOL  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_rise,
  output ratio_e code_o,
  output logic   high_rate_o,
  output logic   valid_o
);
  localparam int CNT_W = $clog2(UNIT * 8 + TOL + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]      cnt;
  logic                  seen;
  ratio_e                prev, cls;
  logic [NUM_RATIOS-1:0] hit;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam int R = UNIT * ratio_mult(g);
    localparam logic [CNT_W-1:0] LO = CNT_W'(R - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(R + TOL);
    assign hit[g] = (cnt >= LO) && (cnt <= HI);
  end

  always_comb begin
    cls = RATIO_NONE;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (hit[i]) cls = ratio_e'(3'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      seen        <= 1'b0;
      prev        <= RATIO_NONE;
      code_o      <= RATIO_NONE;
      high_rate_o <= 1'b0;
      valid_o     <= 1'b0;
    end else if (frame_rise) begin
      cnt  <= CNT_W'(1);
      seen <= 1'b1;
      if (seen) begin
        prev <= cls;
        if (cls != RATIO_NONE && cls == prev) begin
          valid_o     <= 1'b1;
          code_o      <= cls;
          high_rate_o <= (cls == RATIO_128) || (cls == RATIO_192);
        end else begin
          valid_o <= 1'b0;
        end
      end
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkmode_bclk.sv
module clkmode_bclk #(
  parameter int EDGES = 16,
  parameter int QUIET = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_rise,
  input  logic pin_rise,
  output logic ext_o
);
  localparam int EW = $clog2(EDGES + 1);
  localparam int QW = $clog2(QUIET + 1);
  localparam logic [EW-1:0] EDGES_L = EW'(EDGES);
  localparam logic [QW-1:0] QUIET_L = QW'(QUIET);

  logic [EW-1:0] edge_cnt, edge_nxt;
  logic [QW-1:0] quiet, quiet_nxt;

  always_comb begin
    if (frame_rise)        edge_nxt = pin_rise ? EW'(1) : '0;
    else if (pin_rise && edge_cnt != EDGES_L) edge_nxt = edge_cnt + 1'b1;
    else                   edge_nxt = edge_cnt;
    quiet_nxt = quiet;
    if (frame_rise) begin
      if (edge_cnt != '0)        quiet_nxt = '0;
      else if (quiet != QUIET_L) quiet_nxt = quiet + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      quiet    <= '0;
      ext_o    <= 1'b0;
    end else begin
      edge_cnt <= edge_nxt;
      quiet    <= quiet_nxt;
      if (frame_rise && quiet_nxt == QUIET_L) ext_o <= 1'b0;
      if (pin_rise && edge_nxt == EDGES_L)    ext_o <= 1'b1;
    end
  end
endmodule

// File: rtl/clkmode_deemph.sv
module clkmode_deemph #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_fall,
  input  logic pin_lvl,
  output logic state_o
);
  localparam int RW = $clog2(RUN + 1);
  localparam logic [RW-1:0] RUN_L = RW'(RUN);

  logic          last;
  logic [RW-1:0] run, run_nxt;

  always_comb begin
    if (pin_lvl != last)    run_nxt = RW'(1);
    else if (run != RUN_L)  run_nxt = run + 1'b1;
    else                    run_nxt = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last    <= 1'b0;
      run     <= '0;
      state_o <= 1'b0;
    end else if (frame_fall) begin
      last <= pin_lvl;
      run  <= run_nxt;
      if (run_nxt == RUN_L) state_o <= ~pin_lvl;
    end
  end
endmodule

// File: rtl/clkmode_detect.sv
module clkmode_detect
  import clkmode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATIO_UNIT  = 64,
  parameter int RATIO_TOL   = 2,
  parameter int EDGE_COUNT  = 16,
  parameter int QUIET_FRAMES = 2,
  parameter int DEM_RUN     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk_i,
  input  logic       mode_pin_i,
  output logic [2:0] ratio_code_o,
  output logic       ratio_valid_o,
  output logic       high_rate_o,
  output logic       ext_bclk_o,
  output logic       deemph_o
);
  logic   fr_lvl, fr_lvl_d, pin_lvl, pin_lvl_d;
  logic   frame_rise, frame_fall, pin_rise, dem_state;
  ratio_e code;

  clkmode_sync #(.STAGES(SYNC_STAGES)) u_sync_fr (
    .clk(clk), .rst_n(rst_n), .async_i(frame_clk_i),
    .level_o(fr_lvl), .level_d_o(fr_lvl_d));

  clkmode_sync #(.STAGES(SYNC_STAGES)) u_sync_pin (
    .clk(clk), .rst_n(rst_n), .async_i(mode_pin_i),
    .level_o(pin_lvl), .level_d_o(pin_lvl_d));

  assign frame_rise = fr_lvl & ~fr_lvl_d;
  assign frame_fall = ~fr_lvl & fr_lvl_d;
  assign pin_rise   = pin_lvl & ~pin_lvl_d;

  clkmode_ratio #(.UNIT(RATIO_UNIT), .TOL(RATIO_TOL)) u_ratio (
    .clk(clk), .rst_n(rst_n), .frame_rise(frame_rise),
    .code_o(code), .high_rate_o(high_rate_o), .valid_o(ratio_valid_o));

  clkmode_bclk #(.EDGES(EDGE_COUNT), .QUIET(QUIET_FRAMES)) u_bclk (
    .clk(clk), .rst_n(rst_n), .frame_rise(frame_rise),
    .pin_rise(pin_rise), .ext_o(ext_bclk_o));

  clkmode_deemph #(.RUN(DEM_RUN)) u_dem (
    .clk(clk), .rst_n(rst_n), .frame_fall(frame_fall),
    .pin_lvl(pin_lvl), .state_o(dem_state));

  assign ratio_code_o = code;
  assign deemph_o     = dem_state & ~ext_bclk_o & ~high_rate_o;
endmodule

// File: rtl/clkmode_detect_chk.sv
module clkmode_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ratio_code_o,
  input logic       ratio_valid_o,
  input logic       high_rate_o,
  input logic       ext_bclk_o,
  input logic       deemph_o,
  input logic       frame_rise,
  input logic       frame_fall,
  input logic       pin_rise,
  input logic       dem_state
);
  assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid_o) |-> $past(frame_rise));

  assert_ext_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_bclk_o) |-> $past(frame_rise));

  assert_ext_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_bclk_o) |-> $past(pin_rise));

  assert_dem_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dem_state) |-> $past(frame_fall));

  assert_dem_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deemph_o |-> (!ext_bclk_o && !high_rate_o));

  assert_hr_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    high_rate_o |-> (ratio_code_o <= 3'd1));

  assert_valid_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid_o |-> (ratio_code_o <= 3'd4));
endmodule

bind clkmode_detect clkmode_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ratio_code_o(ratio_code_o),
  .ratio_valid_o(ratio_valid_o), .high_rate_o(high_rate_o),
  .ext_bclk_o(ext_bclk_o), .deemph_o(deemph_o),
  .frame_rise(frame_rise), .frame_fall(frame_fall),
  .pin_rise(pin_rise), .dem_state(dem_state));

// File: tb/clkmode_detect_tb.sv
module clkmode_detect_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk = 1'b0;
  logic       mode_pin = 1'b0;
  logic [2:0] ratio_code;
  logic       ratio_valid, high_rate, ext_bclk, deemph;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  clkmode_detect dut_i (
    .clk(clk), .rst_n(rst_n), .frame_clk_i(frame_clk), .mode_pin_i(mode_pin),
    .ratio_code_o(ratio_code), .ratio_valid_o(ratio_valid),
    .high_rate_o(high_rate), .ext_bclk_o(ext_bclk), .deemph_o(deemph));

  // period, pin mode (0 low,1 high,2 toggle), valid, code, high_rate, ext, deemph
  localparam int VN = 12;
  localparam int VEC [VN][7] = '{
    '{256, 0, 1, 2, 0, 0, 1},
    '{384, 1, 1, 3, 0, 0, 0},
    '{512, 0, 1, 4, 0, 0, 1},
    '{128, 0, 1, 0, 1, 0, 0},
    '{192, 0, 1, 1, 1, 0, 0},
    '{256, 2, 1, 2, 0, 1, 0},
    '{257, 1, 1, 2, 0, 0, 0},
    '{300, 0, 0, 2, 0, 0, 1},
    '{254, 0, 1, 2, 0, 0, 1},
    '{253, 0, 0, 2, 0, 0, 1},
    '{514, 1, 1, 4, 0, 0, 0},
    '{126, 0, 1, 0, 1, 0, 0}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // mode 3: np pulses of 2 high/2 low starting at cycle 40
  task automatic frame(input int n, input int mode, input int np, input int from, input int to);
    for (int i = from; i < to; i++) begin
      @(negedge clk);
      frame_clk = (i < n / 2);
      case (mode)
        0: mode_pin = 1'b0;
        1: mode_pin = 1'b1;
        2: mode_pin = ((i % 4) < 2);
        default: mode_pin = (i >= 40) && (i < 40 + 4 * np) && (((i - 40) % 4) < 2);
      endcase
    end
  endtask

  task automatic chk_reset(input string tag);
    chk(tag, "valid", int'(ratio_valid), 0);
    chk(tag, "code", int'(ratio_code), 7);
    chk(tag, "high_rate", int'(high_rate), 0);
    chk(tag, "ext", int'(ext_bclk), 0);
    chk(tag, "deemph", int'(deemph), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk_reset("R9");
    rst_n = 1'b1;

    // R1 R2 R4 R5 R6 R7 R8: table walk
    for (int v = 0; v < VN; v++) begin
      repeat (6) frame(VEC[v][0], VEC[v][1], 0, 0, VEC[v][0]);
      frame(VEC[v][0], VEC[v][1], 0, 0, 12);
      chk("R3", $sformatf("vec%0d valid", v), int'(ratio_valid), VEC[v][2]);
      chk("R1", $sformatf("vec%0d code", v), int'(ratio_code), VEC[v][3]);
      chk("R4", $sformatf("vec%0d high_rate", v), int'(high_rate), VEC[v][4]);
      chk("R5", $sformatf("vec%0d ext", v), int'(ext_bclk), VEC[v][5]);
      chk("R8", $sformatf("vec%0d deemph", v), int'(deemph), VEC[v][6]);
      frame(VEC[v][0], VEC[v][1], 0, 12, VEC[v][0]);
    end

    // R3: one frame at a new ratio drops valid and holds code; second accepts
    frame(256, 0, 0, 0, 256);
    frame(256, 0, 0, 0, 12);
    chk("R3", "first new frame valid", int'(ratio_valid), 0);
    chk("R2", "code held", int'(ratio_code), 0);
    frame(256, 0, 0, 12, 256);
    frame(256, 0, 0, 0, 12);
    chk("R3", "second frame valid", int'(ratio_valid), 1);
    chk("R3", "second frame code", int'(ratio_code), 2);
    frame(256, 0, 0, 12, 256);
    repeat (5) frame(256, 0, 0, 0, 256);

    // R7: 4 high samples keep de-emphasis on, 5th turns it off
    repeat (4) frame(256, 1, 0, 0, 256);
    frame(256, 1, 0, 0, 12);
    chk("R7", "after 4 high", int'(deemph), 1);
    frame(256, 1, 0, 12, 256);
    frame(256, 1, 0, 0, 12);
    chk("R7", "after 5 high", int'(deemph), 0);
    frame(256, 1, 0, 12, 256);

    // R5: 15 edges per frame stay internal, 16 go external
    repeat (3) frame(256, 3, 15, 0, 256);
    frame(256, 3, 0, 0, 12);
    chk("R5", "15 edges", int'(ext_bclk), 0);
    frame(256, 3, 0, 12, 256);
    frame(256, 3, 16, 0, 256);
    frame(256, 3, 0, 0, 12);
    chk("R5", "16 edges", int'(ext_bclk), 1);
    // R6: the frame now running is quiet
    frame(256, 3, 0, 12, 256);
    frame(256, 3, 0, 0, 12);
    chk("R6", "one quiet frame", int'(ext_bclk), 1);
    frame(256, 3, 0, 12, 256);
    frame(256, 3, 0, 0, 12);
    chk("R6", "two quiet frames", int'(ext_bclk), 0);
    frame(256, 3, 0, 12, 256);

    // R9: reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_reset("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule